// File: doc/BRIEF.md
# Compare and Byte-Match ALU

A purely combinational helper datapath for a 32-bit soft processor core. One opcode input selects which of three operations drives the result word: signed compare, unsigned compare, or byte-lane match. A fourth opcode value drives a zero result. A separate carry flag is always present. It reports the carry out of the three-input sum of both operands and the carry-in, whatever the opcode.

Both compare operations return the two's-complement difference `b - a`. The top bit of that word is then replaced so that it flags ordering: it is 1 exactly when `b` is less than `a`, in signed or unsigned terms. The core can branch on that bit alone. The match operation scans the byte lanes of the two operands from the most significant lane downward. It returns the 1-based position of the first equal lane, or zero when no lane matches. The block holds no state. Operand width, lane width and the carry circuit style are parameters.

Top module: `cmp_match_alu`

## Requirements
- R1: With op = 2'b00 (signed compare), result bits 30..0 equal bits 30..0 of `b - a` in two's-complement arithmetic.
- R2: With op = 2'b00, result bit 31 is 1 exactly when `b < a` with both operands read as signed 32-bit integers.
- R3: With op = 2'b01 (unsigned compare), result bits 30..0 equal bits 30..0 of `b - a`, and bit 31 is 1 exactly when `b < a` read as unsigned integers.
- R4: With op = 2'b10 (byte match), the result is k (1 to 4) when byte lane k is the first equal lane. Lanes are counted from lane 1 at bits 31..24 down to lane 4 at bits 7..0. Later matching lanes do not change the result.
- R5: With op = 2'b10 and no equal lane, the result is 0. Result bits 31..3 are always 0 in this mode.
- R6: With op = 2'b11, the result is all zeros for any operands.
- R7: `carry_out` equals the carry out of bit 31 in `a + b + carry_in` for every opcode. This includes `b` all ones with `carry_in` = 1, and `a` all ones with a nonzero addend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 2 | Operation select: 00 signed compare, 01 unsigned compare, 10 byte match, 11 zero result |
| opnd_a | input | 32 | First operand (the subtrahend in compares) |
| opnd_b | input | 32 | Second operand (the minuend in compares) |
| carry_in | input | 1 | Carry-in for the carry flag sum |
| result | output | 32 | Selected result word |
| carry_out | output | 1 | Carry out of `opnd_a + opnd_b + carry_in` |

## Verification
The bench builds the block at 32-bit width with 8-bit lanes. It selects the comparison-based carry circuit rather than the default wide adder, so the special clause for an all-ones `b` with carry-in set is exercised directly. At this width, boundary operands such as 0x80000000, 0x7FFFFFFF, zero and all ones can cross every sign-mismatch case of both compare modes. Crafted byte patterns place a match in each lane, with and without further matches in the lower lanes.

// File: rtl/cmpalu_pkg.sv
package cmpalu_pkg;
   typedef enum logic [1:0] {
      OP_SCMP   = 2'b00,
      OP_UCMP   = 2'b01,
      OP_BMATCH = 2'b10,
      OP_ZERO   = 2'b11
   } alu_op_e;
endpackage

// File: rtl/cmpalu_diff.sv
module cmpalu_diff #(
   parameter int DATA_W = 32
) (
   input  logic              is_signed,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] diff
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] raw;
   logic              sign_split;

   always_comb begin
      raw        = b + ~a + {{(DATA_W-1){1'b0}}, 1'b1};
      sign_split = a[MSB] ^ b[MSB];
      diff       = raw;
      if (sign_split)
         diff[MSB] = is_signed ? b[MSB] : a[MSB];
   end

   // Ordering bit checked against a direct magnitude comparison
   always_comb begin
      if (!$isunknown({is_signed, a, b})) begin
         a_r2_signed_order: assert (!is_signed || (diff[MSB] == ($signed(b) < $signed(a))))
            else $error("signed ordering bit wrong");
         a_r3_unsigned_order: assert (is_signed || (diff[MSB] == (b < a)))
            else $error("unsigned ordering bit wrong");
         a_r1_equal_zero: assert ((a != b) || (diff == '0))
            else $error("equal operands gave nonzero difference");
      end
   end
endmodule

// File: rtl/cmpalu_lane_match.sv
module cmpalu_lane_match #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0]                      a,
   input  logic [DATA_W-1:0]                      b,
   output logic [$clog2(DATA_W/LANE_W + 1)-1:0]   idx
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int IDX_W = $clog2(LANES + 1);

   logic [LANES-1:0] lane_eq;   // bit 0 = most significant lane

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int TOP = DATA_W - 1 - g * LANE_W;
      assign lane_eq[g] = (a[TOP -: LANE_W] == b[TOP -: LANE_W]);
   end

   always_comb begin
      idx = '0;
      for (int i = LANES - 1; i >= 0; i--)
         if (lane_eq[i]) idx = IDX_W'(i + 1);
   end

   always_comb begin
      if (!$isunknown({a, b})) begin
         a_r4_index_range: assert (int'(idx) <= LANES)
            else $error("match index out of range");
         a_r5_zero_means_none: assert ((idx != '0) || (a != b))
            else $error("identical operands reported no match");
         a_r4_top_lane_wins: assert ((a[DATA_W-1 -: LANE_W] != b[DATA_W-1 -: LANE_W]) || (idx == IDX_W'(1)))
            else $error("top lane match not reported as lane 1");
      end
   end
endmodule

// File: rtl/cmpalu_carry.sv
module cmpalu_carry #(
   parameter int DATA_W      = 32,
   parameter int CARRY_STYLE = 0   // 0: widened adder, 1: headroom comparison
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic              cout
);
   if (CARRY_STYLE == 0) begin : g_wide
      logic [DATA_W:0] sum;
      always_comb begin
         sum  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
         cout = sum[DATA_W];
      end
   end else begin : g_headroom
      logic [DATA_W-1:0] headroom;
      logic [DATA_W-1:0] addend;
      always_comb begin
         headroom = {DATA_W{1'b1}} - a;
         addend   = b + {{(DATA_W-1){1'b0}}, cin};
         cout     = (&b && cin) || (headroom < addend);
      end
   end

   always_comb begin
      if (!$isunknown({a, b, cin})) begin
         a_r7_no_carry_from_zero: assert (!((a == '0) && !cin) || !cout)
            else $error("carry from zero operand");
         a_r7_full_wraps: assert (!((&a) && ((b != '0) || cin)) || cout)
            else $error("missing carry from all-ones operand");
      end
   end
endmodule

// File: rtl/cmp_match_alu.sv
module cmp_match_alu
   import cmpalu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int LANE_W      = 8,
   parameter int CARRY_STYLE = 0
) (
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              carry_out
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int IDX_W = $clog2(LANES + 1);

   if (DATA_W < 2)
      $error("DATA_W must be at least 2");
   if (LANE_W < 1 || (DATA_W % LANE_W) != 0)
      $error("LANE_W must divide DATA_W");
   if (CARRY_STYLE != 0 && CARRY_STYLE != 1)
      $error("CARRY_STYLE must be 0 or 1");
   if (IDX_W > DATA_W)
      $error("match index does not fit in result");

   alu_op_e           op_e;
   logic [DATA_W-1:0] cmp_word;
   logic [IDX_W-1:0]  match_idx;

   assign op_e = alu_op_e'(op);

   cmpalu_diff #(.DATA_W(DATA_W)) u_diff (
      .is_signed (op_e == OP_SCMP),
      .a         (opnd_a),
      .b         (opnd_b),
      .diff      (cmp_word)
   );

   cmpalu_lane_match #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_match (
      .a   (opnd_a),
      .b   (opnd_b),
      .idx (match_idx)
   );

   cmpalu_carry #(.DATA_W(DATA_W), .CARRY_STYLE(CARRY_STYLE)) u_carry (
      .a    (opnd_a),
      .b    (opnd_b),
      .cin  (carry_in),
      .cout (carry_out)
   );

   always_comb begin
      unique case (op_e)
         OP_SCMP, OP_UCMP: result = cmp_word;
         OP_BMATCH:        result = {{(DATA_W-IDX_W){1'b0}}, match_idx};
         default:          result = '0;
      endcase
   end

   always_comb begin
      if (!$isunknown({op, opnd_a, opnd_b})) begin
         a_r5_match_upper_clear: assert ((op_e != OP_BMATCH) || (int'(result) <= LANES))
            else $error("match mode result too large");
         a_r6_zero_mode: assert ((op_e != OP_ZERO) || (result == '0))
            else $error("zero mode result nonzero");
      end
   end
endmodule

// File: tb/test_cmp_match_alu.sv
module test_cmp_match_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op = 2'b11;
   logic [31:0] a = '0;
   logic [31:0] b = '0;
   logic        cin = 1'b0;
   logic [31:0] result;
   logic        carry_out;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   cmp_match_alu #(.DATA_W(32), .LANE_W(8), .CARRY_STYLE(1)) i_cmp_match_alu (
      .op        (op),
      .opnd_a    (a),
      .opnd_b    (b),
      .carry_in  (cin),
      .result    (result),
      .carry_out (carry_out)
   );

   function automatic logic [31:0] ref_result(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
      logic [31:0] d;
      d = y - x;
      case (o)
         2'b00: return {($signed(y) < $signed(x)), d[30:0]};
         2'b01: return {(y < x), d[30:0]};
         2'b10: begin
            for (int k = 0; k < 4; k++)
               if (x[31-8*k -: 8] == y[31-8*k -: 8]) return 32'(k + 1);
            return 32'd0;
         end
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic ref_carry(input logic [31:0] x, input logic [31:0] y, input logic c);
      logic [32:0] s;
      s = {1'b0, x} + {1'b0, y} + {32'd0, c};
      return s[32];
   endfunction

   function automatic string req_of(input logic [1:0] o);
      case (o)
         2'b00: return "R1,R2";
         2'b01: return "R3";
         2'b10: return "R4,R5";
         default: return "R6";
      endcase
   endfunction

   task automatic apply_and_check(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                                  input logic c, input string tag);
      logic [31:0] er;
      logic        ec;
      @(posedge clk);
      #1;
      op = o; a = x; b = y; cin = c;
      @(negedge clk);
      er = ref_result(o, x, y);
      ec = ref_carry(x, y, c);
      checks++;
      if (result !== er) begin
         failures++;
         $display("FAIL %s %s op=%b a=%h b=%h actual=%h expected=%h", tag, req_of(o), o, x, y, result, er);
      end
      checks++;
      if (carry_out !== ec) begin
         failures++;
         $display("FAIL %s R7 a=%h b=%h cin=%0d actual=%0d expected=%0d", tag, x, y, c, carry_out, ec);
      end
   endtask

   initial begin
      logic [31:0] corners [5];
      int unsigned seed;
      corners[0] = 32'h0000_0000;
      corners[1] = 32'h8000_0000;
      corners[2] = 32'h7FFF_FFFF;
      corners[3] = 32'hFFFF_FFFF;
      corners[4] = 32'h0000_0001;

      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Idle state after reset: zero mode with zero operands (R6, R7)
      @(negedge clk);
      checks++;
      if (result !== 32'd0 || carry_out !== 1'b0) begin
         failures++;
         $display("FAIL reset R6 actual=%h/%0d expected=00000000/0", result, carry_out);
      end

      // Corner operand crossing, all opcodes, both carry-in values
      for (int i = 0; i < 5; i++)
         for (int j = 0; j < 5; j++)
            for (int o = 0; o < 4; o++)
               apply_and_check(2'(o), corners[i], corners[j], 1'((i + j + o) & 1), "corner");

      // R7 carry corners: b all ones with carry-in, a all ones with addend
      apply_and_check(2'b11, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, "r7_b_ones_cin");
      apply_and_check(2'b00, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "r7_a_ones_cin");
      apply_and_check(2'b01, 32'hFFFF_FFFE, 32'h0000_0001, 1'b1, "r7_exact_wrap");
      apply_and_check(2'b10, 32'hFFFF_FFFE, 32'h0000_0001, 1'b0, "r7_just_below");

      // R4 lane position: match in each lane, lower matches ignored
      apply_and_check(2'b10, 32'h1234_5678, 32'h1299_5678, 1'b0, "r4_lane1_first");
      apply_and_check(2'b10, 32'h1234_5678, 32'hAA34_BB78, 1'b0, "r4_lane2");
      apply_and_check(2'b10, 32'h1234_5678, 32'hAABB_5678, 1'b0, "r4_lane3");
      apply_and_check(2'b10, 32'h1234_5678, 32'hAABB_CC78, 1'b0, "r4_lane4");
      apply_and_check(2'b10, 32'h1234_5678, 32'hEDCB_A987, 1'b0, "r5_no_match");
      apply_and_check(2'b10, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, "r4_all_equal");

      // R2/R3 ordering where the raw difference sign would mislead
      apply_and_check(2'b00, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, "r2_overflow");
      apply_and_check(2'b01, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, "r3_split");
      apply_and_check(2'b00, 32'h0000_0005, 32'h0000_0003, 1'b0, "r2_small");

      // R6: zero mode ignores operands
      apply_and_check(2'b11, 32'hCAFE_F00D, 32'h1357_9BDF, 1'b1, "r6_zero");

      // Constrained random: shared bytes made likely to reach match lanes
      seed = 32'd20240611;
      void'($urandom(seed));
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] x, y;
         logic [3:0]  share;
         x = $urandom;
         y = $urandom;
         share = 4'($urandom);
         for (int k = 0; k < 4; k++)
            if (share[k]) y[8*k +: 8] = x[8*k +: 8];
         if (($urandom % 8) == 0) y[31] = ~x[31];
         apply_and_check(2'($urandom), x, y, 1'($urandom), "random");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired before completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule